// File: doc/BRIEF.md
# External Interrupt Pending Register

This block keeps a 20-bit sticky pending word for external interrupt lines. An upstream detector presents one-cycle event pulses, one per line. Each implemented line latches its own pending bit. Software reads the word and acknowledges lines by writing ones to their positions. Position 10 has no line behind it and always reads zero. Position 19 has no external line either. It records a wake-up: it is set when an RTC alarm arrives while the chip is asleep.

RTC alarms are steered by the sleep state. An alarm taken while asleep sets the wake bit and nothing else. An alarm taken while awake sets no bit here. It is passed on as a one-cycle strobe to the main interrupt controller, which holds the ordinary RTC flags. The register port is a plain write-enable and write-data pair with combinational read data. It never stalls, so there is no back-pressure: every write strobe is applied on the clock edge where it is seen.

Top module: `eint_pend_top`

## Requirements
- R1: After reset, the read data is all zeros and the RTC strobe output is low.
- R2: An event pulse on input bit i, for i in 0..9 or 11..18, sets read-data bit i on the next clock edge. The bit stays set until it is cleared by software.
- R3: Bit 10 always reads 0. Event pulses and writes at position 10 have no effect.
- R4: Event input bit 19 has no effect. Bit 19 is set only by the RTC wake path.
- R5: An RTC alarm pulse while the sleep input is high sets bit 19 on the next edge and leaves the strobe low.
- R6: An RTC alarm pulse while the sleep input is low drives the strobe high for exactly the next cycle and leaves bit 19 unchanged.
- R7: A write with enable high clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R8: If a set (an event pulse or an RTC wake) and a write-1 clear hit the same bit on the same edge, the bit ends up set.
- R9: Read-data bits 31..20 are always 0.
- R10: Write data has no effect while the write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 20 | One-cycle event pulses, one per bit position |
| rtc_alarm_i | input | 1 | One-cycle RTC alarm pulse |
| asleep_i | input | 1 | High while the chip is in sleep mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data; a 1 clears the matching pending bit |
| rd_data_o | output | 32 | Pending word, zero-extended |
| rtc_irq_o | output | 1 | One-cycle RTC strobe toward the main controller |

## Verification
The bench pulses every event input bit at once. This separates the 18 real lines from the reserved position and from the wake position. It then walks a single event bit across all 20 positions, which would show a crossed or shifted bit. Write patterns of all ones, all zeros and alternating bits, with and without the enable, tell clearing apart from holding. RTC alarms are given in both sleep states, and also on the same edge as a clear, so that wake steering and set-over-clear priority are each observed on their own.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef enum logic [1:0] {
    BK_LINE = 2'd0,
    BK_WAKE = 2'd1,
    BK_RSV  = 2'd2
  } bit_kind_e;

  function automatic bit_kind_e kind_of(input int pos, input int rsv_pos, input int wake_pos);
    if (pos == rsv_pos)  return BK_RSV;
    if (pos == wake_pos) return BK_WAKE;
    return BK_LINE;
  endfunction
endpackage

// File: rtl/eint_wake_steer.sv
module eint_wake_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_alarm_i,
  input  logic asleep_i,
  output logic wake_set_o,
  output logic rtc_irq_o
);
  logic irq_q;

  // an alarm taken during sleep only marks the wake bit
  assign wake_set_o = rtc_alarm_i & asleep_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= rtc_alarm_i & ~asleep_i;
  end

  assign rtc_irq_o = irq_q;
endmodule

// File: rtl/eint_pend_bit.sv
module eint_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic q;

  // set has priority so that no event is lost to a concurrent clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (set_i)  q <= 1'b1;
    else if (clr_i)  q <= 1'b0;
  end

  assign pend_o = q;
endmodule

// File: rtl/eint_rd_fmt.sv
module eint_rd_fmt #(
  parameter int PEND_W = 20,
  parameter int DATA_W = 32
) (
  input  logic [PEND_W-1:0] pend_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PAD_W = DATA_W - PEND_W;

  assign rd_data_o = {{PAD_W{1'b0}}, pend_i};
endmodule

// File: rtl/eint_pend_top.sv
module eint_pend_top #(
  parameter int PEND_W   = 20,
  parameter int DATA_W   = 32,
  parameter int RSV_POS  = 10,
  parameter int WAKE_POS = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PEND_W-1:0] evt_i,
  input  logic              rtc_alarm_i,
  input  logic              asleep_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rtc_irq_o
);
  import eint_pkg::*;

  logic              wake_set;
  logic [PEND_W-1:0] set_vec;
  logic [PEND_W-1:0] clr_vec;
  logic [PEND_W-1:0] pend;
  logic              unused_in;

  eint_wake_steer u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .rtc_alarm_i (rtc_alarm_i),
    .asleep_i    (asleep_i),
    .wake_set_o  (wake_set),
    .rtc_irq_o   (rtc_irq_o)
  );

  assign clr_vec = wr_en_i ? wr_data_i[PEND_W-1:0] : '0;

  for (genvar i = 0; i < PEND_W; i++) begin : g_bit
    localparam bit_kind_e KIND = kind_of(i, RSV_POS, WAKE_POS);
    if (KIND == BK_RSV) begin : g_rsv
      assign set_vec[i] = 1'b0;
      assign pend[i]    = 1'b0;
    end else begin : g_live
      if (KIND == BK_WAKE) begin : g_wake
        assign set_vec[i] = wake_set;
      end else begin : g_line
        assign set_vec[i] = evt_i[i];
      end
      eint_pend_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec[i]),
        .clr_i  (clr_vec[i]),
        .pend_o (pend[i])
      );
    end
  end

  assign unused_in = &{1'b0, evt_i[RSV_POS], evt_i[WAKE_POS], clr_vec[RSV_POS],
                       wr_data_i[DATA_W-1:PEND_W]};

  eint_rd_fmt #(.PEND_W(PEND_W), .DATA_W(DATA_W)) u_rd (
    .pend_i    (pend),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/eint_pend_chk.sv
module eint_pend_chk #(
  parameter int PEND_W   = 20,
  parameter int DATA_W   = 32,
  parameter int RSV_POS  = 10,
  parameter int WAKE_POS = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PEND_W-1:0] evt_i,
  input logic              rtc_alarm_i,
  input logic              asleep_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rtc_irq_o
);
  import eint_pkg::*;

  logic [PEND_W-1:0] line_mask;
  logic [PEND_W-1:0] exp_set;
  logic [PEND_W-1:0] exp_clr;

  for (genvar i = 0; i < PEND_W; i++) begin : g_m
    assign line_mask[i] = (kind_of(i, RSV_POS, WAKE_POS) == BK_LINE);
  end

  assign exp_set = (evt_i & line_mask)
                 | ((rtc_alarm_i & asleep_i) ? (PEND_W'(1) << WAKE_POS) : '0);
  assign exp_clr = wr_en_i ? (wr_data_i[PEND_W-1:0] & ~exp_set) : '0;

  // R2 / R8: every requested set is visible next cycle
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data_o[PEND_W-1:0] & $past(exp_set)) == $past(exp_set)));

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[RSV_POS] == 1'b0);

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[DATA_W-1:PEND_W] == '0);

  assert_wake_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_alarm_i && asleep_i) |=> (rd_data_o[WAKE_POS] && !rtc_irq_o));

  assert_awake_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_alarm_i && !asleep_i && !(wr_en_i && wr_data_i[WAKE_POS]))
      |=> (rtc_irq_o && $stable(rd_data_o[WAKE_POS])));

  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rtc_alarm_i && !asleep_i) |=> !rtc_irq_o);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((rd_data_o[PEND_W-1:0] & $past(exp_clr)) == '0));
endmodule

bind eint_pend_top eint_pend_chk #(
  .PEND_W(PEND_W), .DATA_W(DATA_W), .RSV_POS(RSV_POS), .WAKE_POS(WAKE_POS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .rtc_alarm_i (rtc_alarm_i),
  .asleep_i    (asleep_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .rtc_irq_o   (rtc_irq_o)
);

// File: tb/eint_pend_top_tb.sv
module eint_pend_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] evt = '0;
  logic        rtc = 1'b0;
  logic        sleep = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [19:0] model = '0;
  localparam logic [19:0] LINES = 20'h7FBFF;

  always #4 clk = ~clk;

  eint_pend_top u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rtc_alarm_i(rtc), .asleep_i(sleep),
    .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd), .rtc_irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock of stimulus; model follows the requirements, then outputs are checked
  task automatic step(input string req, input logic [19:0] e, input logic r, input logic s,
                      input logic w, input logic [31:0] d);
    logic [19:0] setv;
    logic [19:0] clrv;
    @(negedge clk);
    evt = e; rtc = r; sleep = s; we = w; wd = d;
    setv = (e & LINES) | ((r && s) ? 20'h80000 : 20'h0);
    clrv = w ? d[19:0] : 20'h0;
    model = setv | (model & ~clrv);
    model[10] = 1'b0;
    @(posedge clk);
    #2;
    evt = '0; rtc = 1'b0; we = 1'b0; wd = '0;
    chk(req, rd, {12'h0, model});
    chk({req, " strobe"}, {31'h0, irq}, {31'h0, r && !s});
  endtask

  task automatic t_reset();
    chk("R1 data", rd, 32'h0);
    chk("R1 strobe", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_all_events();
    step("R2 R3 R4 all events", 20'hFFFFF, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R3 bit10", {31'h0, rd[10]}, 32'h0);
    chk("R4 bit19", {31'h0, rd[19]}, 32'h0);
    step("R2 sticky", 20'h0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_clear();
    step("R10 enable low", 20'h0, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF);
    step("R7 write zeros", 20'h0, 1'b0, 1'b0, 1'b1, 32'h0);
    step("R7 alternating clear", 20'h0, 1'b0, 1'b0, 1'b1, 32'h000AAAAA);
    step("R3 write bit10", 20'h0, 1'b0, 1'b0, 1'b1, 32'h00000400);
    step("R9 write ones", 20'h0, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF);
    chk("R9 upper", {20'h0, rd[31:20]}, 32'h0);
  endtask

  task automatic t_walk();
    for (int i = 0; i < 20; i++) begin
      step("R2 walk set", 20'(1) << i, 1'b0, 1'b0, 1'b0, 32'h0);
      step("R7 walk clear", 20'h0, 1'b0, 1'b0, 1'b1, 32'h000FFFFF);
    end
  endtask

  task automatic t_rtc();
    step("R6 awake alarm", 20'h0, 1'b1, 1'b0, 1'b0, 32'h0);
    step("R6 strobe drops", 20'h0, 1'b0, 1'b0, 1'b0, 32'h0);
    step("R5 sleep alarm", 20'h0, 1'b1, 1'b1, 1'b0, 32'h0);
    chk("R5 bit19", {31'h0, rd[19]}, 32'h1);
    step("R6 awake alarm bit19 held", 20'h0, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R6 bit19 kept", {31'h0, rd[19]}, 32'h1);
    step("R7 clear bit19", 20'h0, 1'b0, 1'b0, 1'b1, 32'h00080000);
  endtask

  task automatic t_collide();
    step("R8 line set vs clear", 20'h00008, 1'b0, 1'b0, 1'b1, 32'h00000008);
    chk("R8 bit3", {31'h0, rd[3]}, 32'h1);
    step("R8 wake set vs clear", 20'h0, 1'b1, 1'b1, 1'b1, 32'h00080000);
    chk("R8 bit19", {31'h0, rd[19]}, 32'h1);
    step("R7 final clear", 20'h0, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_all_events();
        t_clear();
        t_walk();
        t_rtc();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule